// File: doc/BRIEF.md
# Secondary Interrupt Controller with Per-Line Passthrough

This block gathers a bank of level-sensitive interrupt request lines and presents them to a primary interrupt controller in two ways. Every input can be enabled into a single combined request that is driven on one fixed parent line (the summary line). In addition, a hard-wired window of inputs can each be routed straight to the parent line with the same number, so that the primary controller sees those sources individually without going through the summary.

Software controls the block through a small word-indexed register bus: select, write strobe, word index, write data and read data. Enable bits and passthrough bits are changed only through separate set and clear registers, so software never needs a read-modify-write. A software-interrupt pair of registers gives single-bit access to enable bit 0. All parent outputs are registered, and read data is returned one clock after the read.

Top module: `sub_irq_ctrl`

## Requirements
- R1: While `rst` is high the captured input level, the enable mask and the passthrough mask are all zero, `parent_irq` is all zero and `bus_rdata` is zero.
- R2: Each rising clock edge copies `irq_in` into the captured level register; a read of word index 1 returns that captured level.
- R3: `parent_irq[31]` is high exactly when the captured level ANDed with the enable mask is non-zero; a read of word index 0 returns that AND.
- R4: A write to word index 2 ORs `bus_wdata` into the enable mask; a write to word index 3 clears every enable bit that is 1 in `bus_wdata`; a read of word index 2 returns the enable mask.
- R5: A write of non-zero data to word index 4 sets enable bit 0, a write of non-zero data to word index 5 clears enable bit 0, a write of zero to either changes nothing; a read of word index 4 returns captured level bit 0 in bit 0 and zeros above.
- R6: A write to word index 8 ORs `bus_wdata` bits 21 to 30 (mask 0x7FE00000) into the passthrough mask, other bits being dropped; a write to word index 9 clears the passthrough bits that are 1 in `bus_wdata`; a read of word index 8 returns the passthrough mask.
- R7: For each line i from 21 to 30, `parent_irq[i]` equals captured level bit i while passthrough bit i is set and is low otherwise; `parent_irq[20:0]` are always low.
- R8: The whole word index is decoded: a read of any index other than 0, 1, 2, 4 or 8 returns zero, and a write to any index other than 2, 3, 4, 5, 8 or 9 changes no state.
- R9: `parent_irq` is registered and reflects the captured level and masks of the previous cycle, so an input change reaches it on the second rising edge and a register write on the edge after the write; `bus_rdata` is valid in the cycle after a read select and zero in cycles after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt request inputs |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_idx | input | 10 | Word index of the register (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| parent_irq | output | 32 | Registered lines to the primary controller; bit 31 is the summary |

## Verification
The main function is driven from a vector table that alternates input patterns with register writes: a pattern with raw activity but no enables tells masked from unmasked summary, a pattern spanning lines 0, 21, 22, 29 and 30 separates the passthrough window from lines below it and from the summary bit, and a pattern with one line both enabled and passed through shows the summary and the passthrough driven together. Set and clear writes are interleaved with read-back so each mask update is seen both at the register and at `parent_irq`. Directed steps then cover writes with zero data to the software-interrupt pair, writes to unlisted and high-bit indices, the two-edge input latency, the read-data return to zero and a reset applied with every mask populated.

// File: rtl/sic_pkg.sv
package sic_pkg;

  typedef enum logic [3:0] {
    RG_STATUS,
    RG_RAW,
    RG_EN_SET,
    RG_EN_CLR,
    RG_SOFT_SET,
    RG_SOFT_CLR,
    RG_PT_SET,
    RG_PT_CLR,
    RG_NONE
  } sic_reg_e;

  // Word index map; the positions are what software relies on.
  localparam int unsigned IX_STATUS   = 0;
  localparam int unsigned IX_RAW      = 1;
  localparam int unsigned IX_EN_SET   = 2;
  localparam int unsigned IX_EN_CLR   = 3;
  localparam int unsigned IX_SOFT_SET = 4;
  localparam int unsigned IX_SOFT_CLR = 5;
  localparam int unsigned IX_PT_SET   = 8;
  localparam int unsigned IX_PT_CLR   = 9;

  function automatic sic_reg_e sic_decode(input logic [31:0] idx);
    sic_reg_e r;
    case (idx)
      IX_STATUS:   r = RG_STATUS;
      IX_RAW:      r = RG_RAW;
      IX_EN_SET:   r = RG_EN_SET;
      IX_EN_CLR:   r = RG_EN_CLR;
      IX_SOFT_SET: r = RG_SOFT_SET;
      IX_SOFT_CLR: r = RG_SOFT_CLR;
      IX_PT_SET:   r = RG_PT_SET;
      IX_PT_CLR:   r = RG_PT_CLR;
      default:     r = RG_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sic_level_cap.sv
module sic_level_cap #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] level_q
);

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= irq_in;
  end

  // R2: captured level follows the inputs of the previous edge
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> level_q == $past(irq_in));

endmodule

// File: rtl/sic_regfile.sv
module sic_regfile
  import sic_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 10,
  parameter int PT_LO   = 21,
  parameter int PT_HI   = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_idx,
  input  logic [NUM_IRQ-1:0] bus_wdata,
  input  logic [NUM_IRQ-1:0] level_q,
  output logic [NUM_IRQ-1:0] bus_rdata,
  output logic [NUM_IRQ-1:0] en_mask,
  output logic [NUM_IRQ-1:0] pt_mask
);

  function automatic logic [NUM_IRQ-1:0] window_bits();
    logic [NUM_IRQ-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (i >= PT_LO && i <= PT_HI) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_IRQ-1:0] PT_WIN = window_bits();

  sic_reg_e           reg_sel;
  logic               do_wr;
  logic               do_rd;
  logic               data_nz;
  logic [NUM_IRQ-1:0] en_nxt;
  logic [NUM_IRQ-1:0] pt_nxt;
  logic [NUM_IRQ-1:0] rd_val;

  assign reg_sel = sic_decode(32'(bus_idx));
  assign do_wr   = bus_sel & bus_wr;
  assign do_rd   = bus_sel & ~bus_wr;
  assign data_nz = |bus_wdata;

  always_comb begin
    en_nxt = en_mask;
    pt_nxt = pt_mask;
    if (do_wr) begin
      unique case (reg_sel)
        RG_EN_SET:   en_nxt = en_mask | bus_wdata;
        RG_EN_CLR:   en_nxt = en_mask & ~bus_wdata;
        RG_SOFT_SET: if (data_nz) en_nxt[0] = 1'b1;
        RG_SOFT_CLR: if (data_nz) en_nxt[0] = 1'b0;
        RG_PT_SET:   pt_nxt = pt_mask | (bus_wdata & PT_WIN);
        RG_PT_CLR:   pt_nxt = pt_mask & ~bus_wdata;
        default:     ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (reg_sel)
      RG_STATUS:   rd_val = level_q & en_mask;
      RG_RAW:      rd_val = level_q;
      RG_EN_SET:   rd_val = en_mask;
      RG_SOFT_SET: rd_val[0] = level_q[0];
      RG_PT_SET:   rd_val = pt_mask;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_mask   <= '0;
      pt_mask   <= '0;
      bus_rdata <= '0;
    end else begin
      en_mask   <= en_nxt;
      pt_mask   <= pt_nxt;
      bus_rdata <= do_rd ? rd_val : '0;
    end
  end

  // R1: masks cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (en_mask == '0 && pt_mask == '0 && bus_rdata == '0));

  // R4: set and clear of the enable mask
  a_r4_en_set: assert property (@(posedge clk) disable iff (rst)
    (do_wr && reg_sel == RG_EN_SET) |=> ((en_mask & $past(bus_wdata)) == $past(bus_wdata)));
  a_r4_en_clr: assert property (@(posedge clk) disable iff (rst)
    (do_wr && reg_sel == RG_EN_CLR) |=> ((en_mask & $past(bus_wdata)) == '0));

  // R5: zero data to the software pair leaves the mask alone
  a_r5_soft_zero: assert property (@(posedge clk) disable iff (rst)
    (do_wr && !data_nz && (reg_sel == RG_SOFT_SET || reg_sel == RG_SOFT_CLR)) |=> $stable(en_mask));

  // R6: passthrough bits never leave the window
  a_r6_pt_window: assert property (@(posedge clk) disable iff (rst)
    (pt_mask & ~PT_WIN) == '0);

  // R8: writes to unlisted indices change nothing
  a_r8_ignore_write: assert property (@(posedge clk) disable iff (rst)
    (do_wr && reg_sel == RG_NONE) |=> ($stable(en_mask) && $stable(pt_mask)));

  // R9: read data idles at zero after a cycle with no read
  a_r9_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !do_rd |=> bus_rdata == '0);

endmodule

// File: rtl/sic_out_comb.sv
module sic_out_comb #(
  parameter int NUM_IRQ = 32,
  parameter int PT_LO   = 21,
  parameter int PT_HI   = 30,
  parameter int SUM_IDX = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] level_q,
  input  logic [NUM_IRQ-1:0] en_mask,
  input  logic [NUM_IRQ-1:0] pt_mask,
  output logic [NUM_IRQ-1:0] parent_irq
);

  logic [NUM_IRQ-1:0] par_nxt;
  logic               summary;

  assign summary = |(level_q & en_mask);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    if (i == SUM_IDX) begin : g_sum
      assign par_nxt[i] = summary;
    end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
      assign par_nxt[i] = level_q[i] & pt_mask[i];
    end else begin : g_low
      assign par_nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) parent_irq <= '0;
    else     parent_irq <= par_nxt;
  end

  // R3: summary line tracks the masked level one cycle later
  a_r3_summary: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> parent_irq[SUM_IDX] == $past((level_q & en_mask) != '0));

  // R7: passthrough line follows level only when enabled
  for (genvar j = PT_LO; j <= PT_HI; j++) begin : g_chk
    a_r7_pass_follow: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(pt_mask[j])) |-> !parent_irq[j]);
  end

  // R7: lines below the window are held low
  a_r7_low_lines: assert property (@(posedge clk) disable iff (rst)
    parent_irq[PT_LO-1:0] == '0);

endmodule

// File: rtl/sub_irq_ctrl.sv
module sub_irq_ctrl #(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 10,
  parameter int PT_LO   = 21,
  parameter int PT_HI   = 30,
  parameter int SUM_IDX = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_idx,
  input  logic [NUM_IRQ-1:0] bus_wdata,
  output logic [NUM_IRQ-1:0] bus_rdata,
  output logic [NUM_IRQ-1:0] parent_irq
);

  logic [NUM_IRQ-1:0] level_q;
  logic [NUM_IRQ-1:0] en_mask;
  logic [NUM_IRQ-1:0] pt_mask;

  sic_level_cap #(.NUM_IRQ(NUM_IRQ)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .level_q (level_q)
  );

  sic_regfile #(
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W),
    .PT_LO   (PT_LO),
    .PT_HI   (PT_HI)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .level_q   (level_q),
    .bus_rdata (bus_rdata),
    .en_mask   (en_mask),
    .pt_mask   (pt_mask)
  );

  sic_out_comb #(
    .NUM_IRQ (NUM_IRQ),
    .PT_LO   (PT_LO),
    .PT_HI   (PT_HI),
    .SUM_IDX (SUM_IDX)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .level_q    (level_q),
    .en_mask    (en_mask),
    .pt_mask    (pt_mask),
    .parent_irq (parent_irq)
  );

endmodule

// File: tb/sub_irq_ctrl_test.sv
module sub_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] parent_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sub_irq_ctrl uut (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_idx    (bus_idx),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .parent_irq (parent_irq)
  );

  // Vector: kind[79:78] req[77:74] idx[73:64] data[63:32] expect[31:0]
  // kind 0 = drive inputs, check parent_irq; 1 = write, check parent_irq; 2 = read, check rdata
  localparam int NV = 23;
  localparam logic [79:0] VEC [NV] = '{
    {2'd0, 4'd3, 10'd0, 32'h8000_0003, 32'h0000_0000},
    {2'd2, 4'd2, 10'd1, 32'h0,         32'h8000_0003},
    {2'd2, 4'd3, 10'd0, 32'h0,         32'h0000_0000},
    {2'd1, 4'd4, 10'd2, 32'h0000_0002, 32'h8000_0000},
    {2'd2, 4'd3, 10'd0, 32'h0,         32'h0000_0002},
    {2'd2, 4'd4, 10'd2, 32'h0,         32'h0000_0002},
    {2'd1, 4'd4, 10'd3, 32'h0000_0002, 32'h0000_0000},
    {2'd1, 4'd5, 10'd4, 32'h0000_0010, 32'h8000_0000},
    {2'd2, 4'd5, 10'd4, 32'h0,         32'h0000_0001},
    {2'd1, 4'd5, 10'd5, 32'h0000_0000, 32'h8000_0000},
    {2'd2, 4'd5, 10'd2, 32'h0,         32'h0000_0001},
    {2'd1, 4'd5, 10'd5, 32'h0000_FFFF, 32'h0000_0000},
    {2'd0, 4'd7, 10'd0, 32'h6060_0001, 32'h0000_0000},
    {2'd1, 4'd6, 10'd8, 32'hFFFF_FFFF, 32'h6060_0000},
    {2'd2, 4'd6, 10'd8, 32'h0,         32'h7FE0_0000},
    {2'd1, 4'd6, 10'd9, 32'h2000_0000, 32'h4060_0000},
    {2'd0, 4'd7, 10'd0, 32'h0020_0000, 32'h0020_0000},
    {2'd1, 4'd8, 10'd7, 32'hFFFF_FFFF, 32'h0020_0000},
    {2'd2, 4'd8, 10'd2, 32'h0,         32'h0000_0000},
    {2'd2, 4'd6, 10'd8, 32'h0,         32'h5FE0_0000},
    {2'd2, 4'd8, 10'd7, 32'h0,         32'h0000_0000},
    {2'd1, 4'd7, 10'd2, 32'h0020_0000, 32'h8020_0000},
    {2'd2, 4'd3, 10'd0, 32'h0,         32'h0020_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [9:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = idx;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_input(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  logic [79:0] vec;
  logic [31:0] rd;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 parent_irq in reset", parent_irq, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      vec = VEC[k];
      case (vec[79:78])
        2'd0: begin
          do_input(vec[63:32]);
          check($sformatf("R%0d vec %0d inputs -> parent_irq", vec[77:74], k), parent_irq, vec[31:0]);
        end
        2'd1: begin
          do_write(vec[73:64], vec[63:32]);
          check($sformatf("R%0d vec %0d write -> parent_irq", vec[77:74], k), parent_irq, vec[31:0]);
        end
        default: begin
          do_read(vec[73:64], rd);
          check($sformatf("R%0d vec %0d read", vec[77:74], k), rd, vec[31:0]);
        end
      endcase
    end

    // R9: rdata returns to zero with no read
    @(posedge clk);
    @(negedge clk);
    check("R9 rdata idle", bus_rdata, 32'h0);

    // R8: high index bits are decoded (0x102 is not index 2)
    do_write(10'h102, 32'hFFFF_FFFF);
    do_read(10'd2, rd);
    check("R8 high-bit index write ignored", rd, 32'h0020_0000);
    do_read(10'h108, rd);
    check("R8 high-bit index read zero", rd, 32'h0);

    // R9: input change takes two edges to reach parent_irq
    @(negedge clk);
    irq_in = 32'h0;
    @(posedge clk);
    @(negedge clk);
    check("R9 one edge after input drop", parent_irq, 32'h8020_0000);
    @(posedge clk);
    @(negedge clk);
    check("R9 two edges after input drop", parent_irq, 32'h0);

    // R5: read index 4 with level bit 0 low
    do_read(10'd4, rd);
    check("R5 soft read low", rd, 32'h0);

    // R1: reset with masks populated
    do_write(10'd2, 32'hFFFF_FFFF);
    do_input(32'hFFFF_FFFF);
    check("R3 all enabled and passed", parent_irq, 32'hDFE0_0000);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1 parent_irq after mid-run reset", parent_irq, 32'h0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 parent_irq after release", parent_irq, 32'h0);
    do_read(10'd2, rd);
    check("R1 enable mask cleared", rd, 32'h0);
    do_read(10'd8, rd);
    check("R1 passthrough mask cleared", rd, 32'h0);
    do_read(10'd1, rd);
    check("R2 raw level after reset", rd, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule